// File: doc/BRIEF.md
# Training-Pattern Word Framer

The framer sits after a 10-bit deserializer whose word boundaries land at an unknown bit position because the delay across the link is not known. Each cycle it captures one incoming word and keeps the word before it. It then takes a contiguous 10-bit slice of the 20-bit pair, chosen by a shift offset, and presents that slice as the framed word.

During link bring-up the far end sends two complementary training words that alternate. A matcher and a small controller step the offset one position at a time until the framed output shows that alternation. After a run of confirming matches the offset is frozen and a locked flag is raised. The offset stays frozen until a re-initialize request arrives. A scan override can force the offset to a chosen value and park the controller. The offset, the controller state and the unframed word are brought out for observation.

Top module: `word_framer`

## Requirements
- R1: While reset is held and just after it, the offset is 0, the state code is 0 (search) and `locked` is 0.
- R2: With offset k, `framed_word` equals bits 19-k down to 10-k of the window {previous word, current word}, where bit 9 of each word is the first-received bit. Offset 0 gives the previous word unchanged. The offset never exceeds 9.
- R3: The training words are A = 0101010100 and B = 1010101011. A match means the framed word equals A or B and differs from the framed word of the previous cycle, so a training word repeated on consecutive cycles is not a match.
- R4: In search (code 0), a cycle without a match advances the offset by one, wrapping from 9 to 0, at the next clock edge.
- R5: A match in search enters verify (code 1). Four further consecutive matches in verify enter locked (code 2) on the fourth. A mismatch in verify returns to search.
- R6: In locked, `locked` is 1, and the offset and the state stay fixed whatever data arrives.
- R7: A re-initialize request returns the controller to search and clears `locked` at the next edge, keeping the current offset.
- R8: While the scan override is high, the offset takes the scanned value at the next edge, clamped to 9 for larger values. The state is hold (code 3) and `locked` is 0. When the override is released, the controller goes to search with the forced offset. The override takes priority over a re-initialize request.
- R9: `raw_word` shows the most recently captured input word before framing.
- R10: For any bit misalignment d from 0 to 9 of the alternating training stream, the framer locks within 40 words of a re-initialize request, with offset d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one deserialized word per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 10 | Incoming deserialized word, bit 9 first received |
| reinit | input | 1 | Re-initialize request: restart the search |
| scan_force | input | 1 | Scan override: force the offset and hold the controller |
| scan_offset | input | 4 | Offset value applied while overriding |
| framed_word | output | 10 | Word-aligned output slice |
| raw_word | output | 10 | Captured word before framing |
| cur_offset | output | 4 | Current funnel shift offset |
| fsm_state | output | 2 | Controller state: 0 search, 1 verify, 2 locked, 3 hold |
| locked | output | 1 | Alignment locked |

## Verification
The assertions expect `reinit` and `scan_force` to be driven synchronously. They take no position on data content: match sequences are whatever the stream produces. They do rely on the override having priority over the re-initialize request, and on the request having priority over the data-driven transitions. The stimulus changes all inputs between clock edges, shortly after each rising edge.

Random words are used only where no match can matter: under the override, or after lock. The search-stepping and repeated-word cases use constant streams that cannot match by accident. Alignment is exercised with training streams built in the bench for several delays. The bench drives two all-zero words before each timed re-initialize, so no stale random data can start a false verify.

// File: rtl/wfr_pkg.sv
package wfr_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2,
    ST_HOLD   = 2'd3
  } wfr_state_e;
endpackage

// File: rtl/wfr_window.sv
module wfr_window #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_word,
  output logic [W-1:0] cur_word,
  output logic [W-1:0] prev_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_word  <= '0;
      prev_word <= '0;
    end else begin
      cur_word  <= in_word;
      prev_word <= cur_word;
    end
  end
endmodule

// File: rtl/wfr_funnel.sv
module wfr_funnel #(
  parameter int W     = 10,
  parameter int OFF_W = 4
) (
  input  logic [W-1:0]     prev_word,
  input  logic [W-1:0]     cur_word,
  input  logic [OFF_W-1:0] offset,
  output logic [W-1:0]     framed
);
  localparam int WIN_W = 2 * W;

  // Earliest bit sits at the top of the window; offset k skips k bits.
  function automatic logic [W-1:0] take_slice(input logic [WIN_W-1:0] win,
                                               input logic [OFF_W-1:0] k);
    logic [WIN_W-1:0] sh;
    sh = win << k;
    return sh[WIN_W-1 -: W];
  endfunction

  logic [WIN_W-1:0] window;
  assign window = {prev_word, cur_word};
  assign framed = take_slice(window, offset);
endmodule

// File: rtl/wfr_matcher.sv
module wfr_matcher #(
  parameter int           W       = 10,
  parameter logic [W-1:0] TRAIN_A = 10'b0101010100,
  parameter logic [W-1:0] TRAIN_B = 10'b1010101011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] framed,
  output logic         is_train,
  output logic         match
);
  logic [W-1:0] last_framed;

  always_ff @(posedge clk) begin
    if (!rst_n) last_framed <= '0;
    else        last_framed <= framed;
  end

  assign is_train = (framed == TRAIN_A) || (framed == TRAIN_B);
  assign match    = is_train && (framed != last_framed);

  AST_MATCH_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (last_framed != $past(last_framed)) || !$past(rst_n)); // R3
endmodule

// File: rtl/wfr_ctrl.sv
module wfr_ctrl
  import wfr_pkg::*;
#(
  parameter int W        = 10,
  parameter int OFF_W    = 4,
  parameter int VERIFY_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             match,
  input  logic             reinit,
  input  logic             scan_force,
  input  logic [OFF_W-1:0] scan_offset,
  output logic [OFF_W-1:0] offset,
  output wfr_state_e       state,
  output logic             locked
);
  localparam int CNT_W = $clog2(VERIFY_N + 1);
  localparam logic [OFF_W-1:0] OFF_MAX  = OFF_W'(W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(VERIFY_N - 1);

  function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] k);
    return (k >= OFF_MAX) ? '0 : k + 1'b1;
  endfunction

  function automatic logic [OFF_W-1:0] clamp_off(input logic [OFF_W-1:0] k);
    return (k > OFF_MAX) ? OFF_MAX : k;
  endfunction

  wfr_state_e       state_q, state_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Named events for the assertions below.
  logic data_driven, search_miss, verify_done;
  assign data_driven = !scan_force && !reinit;
  assign search_miss = data_driven && (state_q == ST_SEARCH) && !match;
  assign verify_done = data_driven && (state_q == ST_VERIFY) && match && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    off_d   = off_q;
    cnt_d   = cnt_q;
    if (scan_force) begin
      state_d = ST_HOLD;
      off_d   = clamp_off(scan_offset);
      cnt_d   = '0;
    end else if (reinit) begin
      state_d = ST_SEARCH;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_SEARCH: begin
          if (match) begin
            state_d = ST_VERIFY;
            cnt_d   = '0;
          end else begin
            off_d = next_off(off_q);
          end
        end
        ST_VERIFY: begin
          if (!match)          state_d = ST_SEARCH;
          else if (verify_done) state_d = ST_LOCKED;
          else                  cnt_d = cnt_q + 1'b1;
        end
        ST_LOCKED: ;
        ST_HOLD:   state_d = ST_SEARCH;
        default:   state_d = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      off_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      cnt_q   <= cnt_d;
    end
  end

  assign offset = off_q;
  assign state  = state_q;
  assign locked = (state_q == ST_LOCKED);

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OFF_MAX); // R2
  AST_SEARCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    search_miss |=> off_q == next_off($past(off_q))); // R4
  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(state_q) == ST_VERIFY) && $past(match)); // R5
  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKED && data_driven) |=> (state_q == ST_LOCKED) && $stable(off_q)); // R6
  AST_REINIT_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit && !scan_force) |=> (state_q == ST_SEARCH) && !locked); // R7
  AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    scan_force |=> (state_q == ST_HOLD) && !locked); // R8
endmodule

// File: rtl/word_framer.sv
module word_framer
  import wfr_pkg::*;
#(
  parameter int                 WORD_W   = 10,
  parameter int                 VERIFY_N = 4,
  parameter logic [WORD_W-1:0]  TRAIN_A  = 10'b0101010100,
  parameter logic [WORD_W-1:0]  TRAIN_B  = 10'b1010101011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              reinit,
  input  logic              scan_force,
  input  logic [3:0]        scan_offset,
  output logic [WORD_W-1:0] framed_word,
  output logic [WORD_W-1:0] raw_word,
  output logic [3:0]        cur_offset,
  output logic [1:0]        fsm_state,
  output logic              locked
);
  localparam int OFF_W = 4;

  logic [WORD_W-1:0] cur_w, prev_w, framed_w;
  logic              is_train, match;
  logic [OFF_W-1:0]  offset;
  wfr_state_e        state;

  wfr_window #(.W(WORD_W)) u_window (
    .clk(clk), .rst_n(rst_n), .in_word(rx_word),
    .cur_word(cur_w), .prev_word(prev_w)
  );

  wfr_funnel #(.W(WORD_W), .OFF_W(OFF_W)) u_funnel (
    .prev_word(prev_w), .cur_word(cur_w), .offset(offset), .framed(framed_w)
  );

  wfr_matcher #(.W(WORD_W), .TRAIN_A(TRAIN_A), .TRAIN_B(TRAIN_B)) u_matcher (
    .clk(clk), .rst_n(rst_n), .framed(framed_w), .is_train(is_train), .match(match)
  );

  wfr_ctrl #(.W(WORD_W), .OFF_W(OFF_W), .VERIFY_N(VERIFY_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .match(match), .reinit(reinit),
    .scan_force(scan_force), .scan_offset(scan_offset),
    .offset(offset), .state(state), .locked(locked)
  );

  assign framed_word = framed_w;
  assign raw_word    = cur_w;
  assign cur_offset  = offset;
  assign fsm_state   = state;

  AST_TRAIN_WHEN_LOCKING: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == 2'd1 && !reinit && !scan_force && !is_train) |=> fsm_state == 2'd0); // R5
endmodule

// File: tb/word_framer_bench.sv
module word_framer_bench;
  localparam logic [9:0] TA = 10'b0101010100;
  localparam logic [9:0] TB = 10'b1010101011;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, reinit, scan_force;
  logic [9:0] rx_word;
  logic [3:0] scan_offset;
  logic [9:0] framed_word, raw_word;
  logic [3:0] cur_offset;
  logic [1:0] fsm_state;
  logic       locked;

  word_framer u_word_framer (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .reinit(reinit),
    .scan_force(scan_force), .scan_offset(scan_offset),
    .framed_word(framed_word), .raw_word(raw_word), .cur_offset(cur_offset),
    .fsm_state(fsm_state), .locked(locked)
  );

  int checks = 0, failures = 0;
  logic [9:0] h0 = '0, h1 = '0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] w);
    rx_word = w;
    @(posedge clk);
    #1;
    h1 = h0;
    h0 = w;
  endtask

  function automatic logic [9:0] exp_slice(input logic [9:0] p, input logic [9:0] c, input int k);
    logic [19:0] win;
    logic [9:0]  r;
    win = {p, c};
    for (int j = 0; j < 10; j++) r[9-j] = win[19-k-j];
    return r;
  endfunction

  // Word n of a stream whose training sequence starts d bits late.
  function automatic logic [9:0] train_word(input int n, input int d);
    logic [9:0] r, tw;
    int p, t;
    for (int j = 0; j < 10; j++) begin
      p = 10 * n + j;
      if (p < d) r[9-j] = 1'b0;
      else begin
        t  = p - d;
        tw = ((t / 10) % 2 == 0) ? TA : TB;
        r[9-j] = tw[9 - (t % 10)];
      end
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic acquire(input int d);
    int n;
    logic [9:0] pf;
    drive('0); drive('0);
    reinit = 1'b1;
    drive(train_word(0, d));
    reinit = 1'b0;
    n = 1;
    for (int i = 0; i < 40 && !locked; i++) begin
      drive(train_word(n, d));
      n++;
    end
    chk("R10 locked", int'(locked), 1);
    chk("R10 offset", int'(cur_offset), d);
    pf = framed_word;
    for (int i = 0; i < 4; i++) begin
      drive(train_word(n, d));
      n++;
      chk("R3 framed is training", int'(framed_word == TA || framed_word == TB), 1);
      chk("R3 framed alternates", int'(framed_word != pf), 1);
      pf = framed_word;
    end
    for (int i = 0; i < 10; i++) begin
      drive(10'($urandom));
      chk("R6 locked held", int'(locked), 1);
      chk("R6 state held", int'(fsm_state), 2);
      chk("R6 offset frozen", int'(cur_offset), d);
    end
    reinit = 1'b1;
    drive(10'($urandom));
    reinit = 1'b0;
    chk("R7 state search", int'(fsm_state), 0);
    chk("R7 locked cleared", int'(locked), 0);
    chk("R7 offset kept", int'(cur_offset), d);
  endtask

  initial begin
    int n, k;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reinit = 1'b0; scan_force = 1'b0; scan_offset = '0; rx_word = '0;
    drive(10'h3ff); drive(10'h155);
    chk("R1 reset offset", int'(cur_offset), 0);
    chk("R1 reset state", int'(fsm_state), 0);
    chk("R1 reset locked", int'(locked), 0);
    rst_n = 1'b1;
    drive('0);
    chk("R1 after reset locked", int'(locked), 0);

    // R4: stepping through offsets on a stream that cannot match
    scan_force = 1'b1; scan_offset = 4'd3;
    drive('0); drive('0);
    scan_force = 1'b0;
    drive('0);
    chk("R8 release to search", int'(fsm_state), 0);
    chk("R8 forced offset kept", int'(cur_offset), 3);
    for (int i = 1; i <= 8; i++) begin
      drive('0);
      chk("R4 offset step", int'(cur_offset), (3 + i) % 10);
    end

    // R3: a repeated training word is no match
    scan_force = 1'b1; scan_offset = 4'd0;
    drive(TA); drive(TA); drive(TA);
    scan_force = 1'b0;
    drive(TA);
    chk("R3 repeat release", int'(cur_offset), 0);
    drive(TA);
    chk("R3 repeat is miss state", int'(fsm_state), 0);
    chk("R3 repeat is miss offset", int'(cur_offset), 1);

    // R2, R8, R9: forced offsets, random data
    for (int t = 0; t < 6; t++) begin
      k = (t == 0) ? 0 : (t == 1) ? 9 : int'($urandom_range(0, 9));
      scan_force = 1'b1; scan_offset = 4'(k);
      reinit = (t == 2);
      drive(10'($urandom));
      reinit = 1'b0;
      chk("R8 forced offset", int'(cur_offset), k);
      chk("R8 hold state", int'(fsm_state), 3);
      chk("R8 not locked", int'(locked), 0);
      for (int i = 0; i < 6; i++) begin
        drive(10'($urandom));
        chk("R2 framed slice", int'(framed_word), int'(exp_slice(h1, h0, k)));
        chk("R9 raw word", int'(raw_word), int'(h0));
      end
    end
    scan_offset = 4'd13;
    drive(10'($urandom));
    chk("R8 clamp", int'(cur_offset), 9);
    scan_force = 1'b0;
    drive('0);

    // R10, R6, R7: acquisition at several delays
    acquire(0); acquire(3); acquire(9); acquire(7);
    acquire(int'($urandom_range(1, 8)));

    // R5: exact verify length
    drive('0); drive('0);
    reinit = 1'b1;
    drive(train_word(0, 0));
    reinit = 1'b0;
    n = 1;
    for (int i = 0; i < 40 && fsm_state != 2'd1; i++) begin
      drive(train_word(n, 0)); n++;
    end
    chk("R5 verify reached", int'(fsm_state), 1);
    for (int i = 0; i < 3; i++) begin drive(train_word(n, 0)); n++; end
    chk("R5 not yet locked", int'(locked), 0);
    drive(train_word(n, 0)); n++;
    chk("R5 locked after four", int'(locked), 1);

    // R5: mismatch in verify falls back
    drive('0); drive('0);
    reinit = 1'b1;
    drive(train_word(0, 0));
    reinit = 1'b0;
    n = 1;
    for (int i = 0; i < 40 && fsm_state != 2'd1; i++) begin
      drive(train_word(n, 0)); n++;
    end
    chk("R5 verify again", int'(fsm_state), 1);
    drive('0); drive('0); drive('0);
    chk("R5 mismatch to search", int'(fsm_state), 0);
    chk("R5 mismatch not locked", int'(locked), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule